// File: doc/BRIEF.md
# Limit Switch Step Gating Counter

This block is the last stage of one motor axis, placed between a step-pulse generator and a stepper driver. It can invert the direction line. It masks and synchronises three limit-switch inputs: anti-collision, inner and outer. Each of these switches is latched on its rising edge. The latch for a switch is held clear while the axis moves in the direction that escapes that switch, so an axis can always back off a switch it has tripped.

The stage builds a motion-enable term from five inputs: the latched switch status, driver readiness, an external stop, an inhibit line and, optionally, the switch status of the other motor on the same jaw. This enable gates the outgoing step pulses. A signed position counter follows the gated step pulses. The host can preload this counter with a reference value. A driver-reset control passes straight through to the driver.

Top module: `axis_step_gate`

## Requirements
- R1: `dirOut` equals `dirIn` XOR `invDir`, combinationally.
- R2: A switch bit reaches its latch only while the matching `swMask` bit is 1. The bit positions are: bit 0 anti-collision, bit 1 inner, bit 2 outer. A switch that is masked off never sets its latch.
- R3: A rising edge on a masked switch input sets that switch's latch. The raw input passes through two synchroniser flops and one edge flop, so the latch is visible on `swStatus` after the third rising clock edge following the change. Once set, a latch stays set after the switch input falls.
- R4: The anti-collision latch and the inner latch are cleared at the next clock edge while `dirOut` is 0. The outer latch is cleared at the next clock edge while `dirOut` is 1.
- R5: While `latchClr` is 1, all three latches are cleared at the next clock edge. Clearing takes priority over setting.
- R6: `swStatus` is the OR of the three latches. While `swDisable` is 1, `swStatus` is forced to 0.
- R7: `jawSwStatus` blocks motion only while `jawEn` is 1. While `jawEn` is 0, `jawSwStatus` has no effect on `stepOut`.
- R8: `stepOut` equals `stepIn` while enabled and is 0 otherwise. The enable term is: not `swStatus`, and `drvReady`, and not `extStop`, and not the qualified jaw status, and not `inhibit`.
- R9: On each rising edge of `stepOut`, `position` changes by +1 when `dirOut` XOR `invCount` is 1 and by -1 otherwise. The update is visible after the clock edge that samples the rise. The counter is signed, 32 bits wide by default, and wraps from 0x7FFFFFFF to 0x80000000.
- R10: While `refLoad` is 1, `position` takes `refValue` at each clock edge. A step rise in the same cycle is ignored.
- R11: `drvResetOut` equals `drvResetIn`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepIn | input | 1 | Step pulse from the generator |
| dirIn | input | 1 | Direction from the generator |
| swRaw | input | 3 | Raw switches: bit 0 anti-collision, bit 1 inner, bit 2 outer |
| swMask | input | 3 | Per-switch enable mask |
| invDir | input | 1 | Invert the direction output |
| invCount | input | 1 | Invert the counting sense |
| latchClr | input | 1 | Clear all switch latches |
| swDisable | input | 1 | Force switch status to 0 |
| jawEn | input | 1 | Use the status of the other motor on the same jaw |
| jawSwStatus | input | 1 | Switch status of the other motor on the same jaw |
| drvReady | input | 1 | Driver ready |
| extStop | input | 1 | External stop |
| inhibit | input | 1 | Motion inhibit |
| refLoad | input | 1 | Load the reference value into the position counter |
| refValue | input | POS_W | Reference position |
| drvResetIn | input | 1 | Driver reset control |
| stepOut | output | 1 | Gated step pulse |
| dirOut | output | 1 | Direction to the driver |
| swStatus | output | 1 | Combined switch status |
| position | output | POS_W | Signed step position |
| drvResetOut | output | 1 | Driver reset to the driver |

## Verification
The bench builds the block with its defaults: three switches and a 32-bit counter. The gating logic has only six control inputs, so the bench sweeps all 64 combinations of them against the enable equation. It also sweeps all eight combinations of direction, direction inversion and count inversion, checking the counting sense for each.

Each switch bit is tripped in both directions and with its mask bit off. This checks the three-edge latch latency and the direction-aware clearing. A preload near the positive limit exercises the counter wrap and the priority of a load over a step.

// File: rtl/axis_step_gate_pkg.sv
package axis_step_gate_pkg;
  localparam int SW_ANTI  = 0;
  localparam int SW_INNER = 1;
  localparam int SW_OUTER = 2;
  localparam int SW_N     = 3;

  typedef struct packed {
    logic loadRef;
    logic stepRise;
    logic countUp;
  } gateStrobes_t;
endpackage

// File: rtl/axis_step_gate_ctrl.sv
module axis_step_gate_ctrl
  import axis_step_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepIn,
  input  logic              dirIn,
  input  logic [SW_N-1:0]   swRaw,
  input  logic [SW_N-1:0]   swMask,
  input  logic              invDir,
  input  logic              invCount,
  input  logic              latchClr,
  input  logic              swDisable,
  input  logic              jawEn,
  input  logic              jawSwStatus,
  input  logic              drvReady,
  input  logic              extStop,
  input  logic              inhibit,
  input  logic              refLoad,
  output logic              stepOut,
  output logic              dirOut,
  output logic              swStatus,
  output gateStrobes_t      strobes
);
  logic [SW_N-1:0] swMasked;
  logic [SW_N-1:0] syncA;
  logic [SW_N-1:0] syncB;
  logic [SW_N-1:0] syncPrev;
  logic [SW_N-1:0] swRise;
  logic [SW_N-1:0] holdClr;
  logic [SW_N-1:0] swLatch;
  logic            stepPrev;
  logic            jawBlock;
  logic            motionEn;

  assign dirOut   = dirIn ^ invDir;
  assign swMasked = swRaw & swMask;

  // The switches that block forward motion escape when DIR is low; the outer switch escapes when DIR is high.
  assign holdClr[SW_ANTI]  = ~dirOut | latchClr;
  assign holdClr[SW_INNER] = ~dirOut | latchClr;
  assign holdClr[SW_OUTER] =  dirOut | latchClr;

  for (genvar g = 0; g < SW_N; g++) begin : g_sw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g]    <= 1'b0;
        syncB[g]    <= 1'b0;
        syncPrev[g] <= 1'b0;
        swLatch[g]  <= 1'b0;
      end else begin
        syncA[g]    <= swMasked[g];
        syncB[g]    <= syncA[g];
        syncPrev[g] <= syncB[g];
        if (holdClr[g])
          swLatch[g] <= 1'b0;
        else if (swRise[g])
          swLatch[g] <= 1'b1;
      end
    end
    assign swRise[g] = syncB[g] & ~syncPrev[g];
  end

  assign swStatus = (|swLatch) & ~swDisable;
  assign jawBlock = jawEn & jawSwStatus;
  assign motionEn = ~swStatus & drvReady & ~extStop & ~jawBlock & ~inhibit;
  assign stepOut  = stepIn & motionEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepPrev <= 1'b0;
    else       stepPrev <= stepOut;
  end

  always_comb begin
    strobes.loadRef  = refLoad;
    strobes.stepRise = stepOut & ~stepPrev;
    strobes.countUp  = dirOut ^ invCount;
  end
endmodule

// File: rtl/axis_step_gate_dpath.sv
module axis_step_gate_dpath
  import axis_step_gate_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobes_t     strobes,
  input  logic [POS_W-1:0] refValue,
  output logic [POS_W-1:0] position
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      position <= '0;
    else if (strobes.loadRef)
      position <= refValue;
    else if (strobes.stepRise)
      position <= strobes.countUp ? position + ONE : position - ONE;
  end
endmodule

// File: rtl/axis_step_gate.sv
module axis_step_gate
  import axis_step_gate_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepIn,
  input  logic             dirIn,
  input  logic [2:0]       swRaw,
  input  logic [2:0]       swMask,
  input  logic             invDir,
  input  logic             invCount,
  input  logic             latchClr,
  input  logic             swDisable,
  input  logic             jawEn,
  input  logic             jawSwStatus,
  input  logic             drvReady,
  input  logic             extStop,
  input  logic             inhibit,
  input  logic             refLoad,
  input  logic [POS_W-1:0] refValue,
  input  logic             drvResetIn,
  output logic             stepOut,
  output logic             dirOut,
  output logic             swStatus,
  output logic [POS_W-1:0] position,
  output logic             drvResetOut
);
  gateStrobes_t strobes;

  axis_step_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn),
    .swRaw(swRaw), .swMask(swMask), .invDir(invDir), .invCount(invCount),
    .latchClr(latchClr), .swDisable(swDisable), .jawEn(jawEn),
    .jawSwStatus(jawSwStatus), .drvReady(drvReady), .extStop(extStop),
    .inhibit(inhibit), .refLoad(refLoad), .stepOut(stepOut),
    .dirOut(dirOut), .swStatus(swStatus), .strobes(strobes)
  );

  axis_step_gate_dpath #(.POS_W(POS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .refValue(refValue), .position(position)
  );

  assign drvResetOut = drvResetIn;
endmodule

// File: rtl/axis_step_gate_chk.sv
module axis_step_gate_chk #(
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepOut,
  input logic             swStatus,
  input logic             swDisable,
  input logic             latchClr,
  input logic             drvReady,
  input logic             extStop,
  input logic             inhibit,
  input logic             refLoad,
  input logic [POS_W-1:0] refValue,
  input logic [POS_W-1:0] position
);
  // R8
  step_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepOut |-> (drvReady && !extStop && !inhibit && !swStatus));
  // R6
  sw_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    swDisable |-> !swStatus);
  // R5
  latch_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchClr && !swDisable) |=> !swStatus);
  // R10
  ref_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    refLoad |=> (position == $past(refValue)));
  // R9
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refLoad && !stepOut) |=> $stable(position));
endmodule

bind axis_step_gate axis_step_gate_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .stepOut(stepOut), .swStatus(swStatus),
  .swDisable(swDisable), .latchClr(latchClr), .drvReady(drvReady),
  .extStop(extStop), .inhibit(inhibit), .refLoad(refLoad),
  .refValue(refValue), .position(position)
);

// File: tb/axis_step_gate_test.sv
`timescale 1ns/1ps
module axis_step_gate_test;
  localparam int POS_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepIn = 0, dirIn = 0, invDir = 0, invCount = 0, latchClr = 0;
  logic swDisable = 0, jawEn = 0, jawSwStatus = 0, drvReady = 1;
  logic extStop = 0, inhibit = 0, refLoad = 0, drvResetIn = 0;
  logic [2:0] swRaw = '0;
  logic [2:0] swMask = 3'b111;
  logic [POS_W-1:0] refValue = '0;
  logic stepOut, dirOut, swStatus, drvResetOut;
  logic [POS_W-1:0] position;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  axis_step_gate #(.POS_W(POS_W)) uut (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn), .swRaw(swRaw),
    .swMask(swMask), .invDir(invDir), .invCount(invCount), .latchClr(latchClr),
    .swDisable(swDisable), .jawEn(jawEn), .jawSwStatus(jawSwStatus),
    .drvReady(drvReady), .extStop(extStop), .inhibit(inhibit),
    .refLoad(refLoad), .refValue(refValue), .drvResetIn(drvResetIn),
    .stepOut(stepOut), .dirOut(dirOut), .swStatus(swStatus),
    .position(position), .drvResetOut(drvResetOut)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); stepIn = 1'b1;
    @(negedge clk); stepIn = 1'b0;
  endtask

  // Trip one switch, confirm the latch and gating, then move in the escape direction.
  task automatic tripSwitch(input int idx, input bit blockDir);
    @(negedge clk); dirIn = blockDir; swRaw = '0; stepIn = 1'b1;
    cyc(3);
    @(negedge clk); swRaw[idx] = 1'b1;
    cyc(2);
    chk(swStatus == 1'b0, "R3 latency", swStatus, 0);
    cyc(1);
    chk(swStatus == 1'b1, "R3 set", swStatus, 1);
    chk(stepOut == 1'b0, "R8 blocked by switch", stepOut, 0);
    swRaw[idx] = 1'b0;
    cyc(4);
    chk(swStatus == 1'b1, "R3 held after fall", swStatus, 1);
    dirIn = ~blockDir;
    cyc(1);
    chk(swStatus == 1'b0, "R4 escape clear", swStatus, 0);
    stepIn = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    cyc(2);
    chk(position == '0 && swStatus == 1'b0, "reset state", position, 0);
    rstN = 1'b1;
    cyc(2);

    // R8 R7 R6: sweep all six gating controls with the step line high
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      {drvReady, extStop, inhibit, jawEn, jawSwStatus, swDisable} = 6'(v);
      stepIn = 1'b1;
      #2;
      chk(stepOut == (drvReady & ~extStop & ~inhibit & ~(jawEn & jawSwStatus)),
          "R8 R7 gating", stepOut, drvReady & ~extStop & ~inhibit & ~(jawEn & jawSwStatus));
    end
    @(negedge clk);
    stepIn = 0; {drvReady, extStop, inhibit, jawEn, jawSwStatus, swDisable} = 6'b100000;

    // R1 R9: direction inversion and counting sense
    for (int v = 0; v < 8; v++) begin
      longint startPos;
      longint expPos;
      @(negedge clk);
      {dirIn, invDir, invCount} = 3'(v);
      #2;
      chk(dirOut == (dirIn ^ invDir), "R1 dir", dirOut, dirIn ^ invDir);
      startPos = longint'($signed(position));
      repeat (3) pulse();
      cyc(1);
      expPos = ((dirIn ^ invDir ^ invCount) != 1'b0) ? startPos + 3 : startPos - 3;
      chk(longint'($signed(position)) == expPos, "R9 count", $signed(position), expPos);
    end
    @(negedge clk); invDir = 0; invCount = 0;

    // R10 R9: load, wrap, load priority over a step
    refValue = 32'h7FFF_FFFF; refLoad = 1'b1;
    cyc(1);
    refLoad = 1'b0;
    chk(position == 32'h7FFF_FFFF, "R10 load", position, 32'h7FFF_FFFF);
    dirIn = 1'b1;
    pulse();
    cyc(1);
    chk(position == 32'h8000_0000, "R9 wrap", position, 32'h8000_0000);
    @(negedge clk); refValue = 32'h0000_1234; refLoad = 1'b1; stepIn = 1'b1;
    @(negedge clk); stepIn = 1'b0;
    @(negedge clk); refLoad = 1'b0;
    cyc(1);
    chk(position == 32'h0000_1234, "R10 priority", position, 32'h1234);

    // R3 R4: each switch in its blocking direction
    tripSwitch(0, 1'b1);
    tripSwitch(1, 1'b1);
    tripSwitch(2, 1'b0);

    // R4: outer switch cannot latch while moving away from it
    @(negedge clk); dirIn = 1'b1; swRaw = 3'b100;
    cyc(5);
    chk(swStatus == 1'b0, "R4 outer held clear", swStatus, 0);
    swRaw = '0; cyc(3);

    // R2: masked switch never latches
    for (int b = 0; b < 3; b++) begin
      @(negedge clk); swMask = ~(3'b001 << b); dirIn = (b != 2); swRaw = 3'(1 << b);
      cyc(5);
      chk(swStatus == 1'b0, "R2 masked", swStatus, 0);
      swRaw = '0; cyc(3);
    end
    swMask = 3'b111;

    // R6 R5: disable hides a set latch; latchClr clears it
    @(negedge clk); dirIn = 1'b1; swRaw = 3'b001;
    cyc(4);
    chk(swStatus == 1'b1, "R3 set for R6", swStatus, 1);
    swDisable = 1'b1; stepIn = 1'b1;
    #2;
    chk(swStatus == 1'b0 && stepOut == 1'b1, "R6 disable", {swStatus, stepOut}, 2'b01);
    @(negedge clk); swDisable = 1'b0; stepIn = 1'b0;
    #2;
    chk(swStatus == 1'b1, "R6 latch kept", swStatus, 1);
    latchClr = 1'b1;
    cyc(1);
    latchClr = 1'b0;
    chk(swStatus == 1'b0, "R5 clear", swStatus, 0);
    swRaw = '0;

    // R11: driver reset passthrough
    drvResetIn = 1'b1; #2;
    chk(drvResetOut == 1'b1, "R11 high", drvResetOut, 1);
    drvResetIn = 1'b0; #2;
    chk(drvResetOut == 1'b0, "R11 low", drvResetOut, 0);

    cyc(2);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule